// File: doc/BRIEF.md
# Vector Condition-Field Fail-First Sequencer

The block runs a vector of condition-field operations one element per clock. A start strobe captures a snapshot of eight 4-bit condition fields (32 bits), a vector length and the mode bits. For each loop position the block works out the element index. This is ascending, or descending when reverse order is selected. It applies the element's predicate bit, combines two source operands through a 4-entry truth table, and emits a write of the resulting destination field. The write also lands in an internal working copy, so later elements see the results of earlier ones. Overlapping operand ranges therefore cascade.

Each field holds, from bit 3 down to bit 0, LT, GT, EQ and SO. A 2-bit bit number b addresses field bit 3-b, so number 0 is LT and number 3 is SO. Two operand encodings exist. The bit-target form uses 5-bit indices: field = idx[4:2], bit number = idx[1:0]. The field-target form uses 3-bit field indices in idx[2:0] together with a separate 2-bit tested-bit selector. When fail-first is on, one bit of each written result is tested against an inversion flag. The first failing test truncates the vector length and stops the loop.

Top module: `cr_ffirst_seq`

## Requirements
- R1: After a start with VL>0, loop position k (k = 0..VL-1) is handled in the k-th busy cycle. Its element index is k, or VL-1-k when `rev` is 1. Element e uses field (base + e) mod 8 for each operand and for the destination.
- R2: The operation is the truth table `op_tt`: the result bit for inputs a (from A) and b (from B) is `op_tt[{a,b}]`. AND is 4'b1000, OR is 4'b1110, XOR is 4'b0110 and NOR is 4'b0001.
- R3: With `fmt5`=1 (bit-target), the destination bit number idx_t[1:0] is replaced by op(A bit, B bit). The bit numbers for A and B are idx_a[1:0] and idx_b[1:0]. The other three destination bits keep their current value, and the tested bit is the bit just written.
- R4: With `fmt5`=0 (field-target), all four destination bits are op(A[j], B[j]) for j = 0..3. The tested bit is bit number `crbit`.
- R5: An element with predicate 0 and `zz`=0 is skipped: no write and no test. With `zz`=1 it is written, and the new bit(s) all equal `snz` in place of the operation result. Such an element is then tested like any other.
- R6: With `ff_en`=1 a test passes when the tested bit differs from `inv`. A failure at loop position k gives `vl_out` = k + `vli`.
- R7: After a failing element no further write occurs, and `done` is high for one cycle in the following cycle. Without a failure, `done` follows the last element and `vl_out` = VL.
- R8: A start with VL=0 makes no write and raises `done` in the next cycle with `vl_out` = 0.
- R9: Writes update the working copy loaded from `cr_in` at start, and later elements read those updated fields.
- R10: After reset, `done` and `wr_en` are 0 and `vl_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a vector run (ignored while busy) |
| vl_in | input | 4 | Vector length |
| rev | input | 1 | Descending element order |
| ff_en | input | 1 | Enable fail-first testing |
| fmt5 | input | 1 | 1: bit-target indices, 0: field-target indices |
| inv | input | 1 | Test sense |
| vli | input | 1 | Count failing element in truncated length |
| crbit | input | 2 | Tested bit number in field-target form |
| zz | input | 1 | Write masked elements instead of skipping |
| snz | input | 1 | Value written for masked elements |
| op_tt | input | 4 | Operation truth table |
| idx_a | input | 5 | Operand A index |
| idx_b | input | 5 | Operand B index |
| idx_t | input | 5 | Destination index |
| pmask | input | 16 | Predicate bit per element index |
| cr_in | input | 32 | Field snapshot, field f at bits 4f+3..4f |
| wr_en | output | 1 | Element write strobe |
| wr_field | output | 3 | Destination field of the write |
| wr_data | output | 4 | New destination field value |
| vl_out | output | 4 | Resulting vector length |
| done | output | 1 | Run finished (one cycle) |

## Verification
Assertions check several properties on every cycle. They check that consecutive writes step the destination field by one in the loop direction. They check that a failed test is followed by `done` with no further write, and that the reported length never exceeds the requested one. They also check that a run without fail-first reports the full length, and that VL=0 finishes at once. Other behaviour can only be shown by the bench's scenarios, each compared with a bench-side model: the exact write values under each operation, the masking, zeroing and one-fill choices, the tested-bit selection with inversion, the inclusive and exclusive counts, and cascading through the working copy in reverse order.

// File: rtl/cr_ffirst_seq.sv
module cr_ffirst_seq #(
  parameter int NF  = 8,
  parameter int VLW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [VLW-1:0]       vl_in,
  input  logic                 rev,
  input  logic                 ff_en,
  input  logic                 fmt5,
  input  logic                 inv,
  input  logic                 vli,
  input  logic [1:0]           crbit,
  input  logic                 zz,
  input  logic                 snz,
  input  logic [3:0]           op_tt,
  input  logic [$clog2(NF)+1:0] idx_a,
  input  logic [$clog2(NF)+1:0] idx_b,
  input  logic [$clog2(NF)+1:0] idx_t,
  input  logic [(1<<VLW)-1:0]  pmask,
  input  logic [NF*4-1:0]      cr_in,
  output logic                 wr_en,
  output logic [$clog2(NF)-1:0] wr_field,
  output logic [3:0]           wr_data,
  output logic [VLW-1:0]       vl_out,
  output logic                 done
);
  localparam int FW = $clog2(NF);
  localparam int IW = FW + 2;
  localparam int MW = 1 << VLW;
  typedef logic [FW-1:0] fw_t;

  logic           busy;
  logic [VLW-1:0] k, vl_q;
  logic           rev_q, ff_q, f5_q, inv_q, vli_q, zz_q, snz_q;
  logic [1:0]     cb_q;
  logic [3:0]     tt_q;
  logic [IW-1:0]  ia_q, ib_q, it_q;
  logic [MW-1:0]  pm_q;
  logic [NF*4-1:0] crr;

  logic [VLW-1:0] e;
  fw_t            off, fa, fb, ft;
  logic [3:0]     va, vb, vt, res5, res3, res;
  logic           pred, active, av, bv, r5, tbit, fail, last;

  assign e    = rev_q ? (vl_q - 1'b1 - k) : k;
  assign off  = e[FW-1:0];
  assign fa   = (f5_q ? ia_q[IW-1:2] : ia_q[FW-1:0]) + off;
  assign fb   = (f5_q ? ib_q[IW-1:2] : ib_q[FW-1:0]) + off;
  assign ft   = (f5_q ? it_q[IW-1:2] : it_q[FW-1:0]) + off;
  assign va   = crr[{fa, 2'b00} +: 4];
  assign vb   = crr[{fb, 2'b00} +: 4];
  assign vt   = crr[{ft, 2'b00} +: 4];
  assign pred   = pm_q[e];
  assign active = busy & (pred | zz_q);
  assign av   = va[~ia_q[1:0]];
  assign bv   = vb[~ib_q[1:0]];
  assign r5   = pred ? tt_q[{av, bv}] : snz_q;

  always_comb begin
    res5 = vt;
    res5[~it_q[1:0]] = r5;
    for (int j = 0; j < 4; j++)
      res3[j] = pred ? tt_q[{va[j], vb[j]}] : snz_q;
  end

  assign res  = f5_q ? res5 : res3;
  assign tbit = f5_q ? r5 : res3[~cb_q];
  assign fail = active & ff_q & (tbit == inv_q);
  assign last = (k == vl_q - 1'b1);

  assign wr_en    = active;
  assign wr_field = ft;
  assign wr_data  = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; vl_out <= '0; k <= '0; vl_q <= '0;
      rev_q <= 1'b0; ff_q <= 1'b0; f5_q <= 1'b0; inv_q <= 1'b0; vli_q <= 1'b0;
      zz_q <= 1'b0; snz_q <= 1'b0; cb_q <= '0; tt_q <= '0;
      ia_q <= '0; ib_q <= '0; it_q <= '0; pm_q <= '0; crr <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          vl_q <= vl_in; k <= '0;
          rev_q <= rev; ff_q <= ff_en; f5_q <= fmt5; inv_q <= inv; vli_q <= vli;
          zz_q <= zz; snz_q <= snz; cb_q <= crbit; tt_q <= op_tt;
          ia_q <= idx_a; ib_q <= idx_b; it_q <= idx_t; pm_q <= pmask; crr <= cr_in;
          if (vl_in == '0) begin
            done <= 1'b1; vl_out <= '0;
          end else begin
            busy <= 1'b1;
          end
        end
      end else begin
        if (active) crr[{ft, 2'b00} +: 4] <= res;
        k <= k + 1'b1;
        if (fail) begin
          busy <= 1'b0; done <= 1'b1; vl_out <= k + VLW'(vli_q);
        end else if (last) begin
          busy <= 1'b0; done <= 1'b1; vl_out <= vl_q;
        end
      end
    end
  end

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_field == fw_t'($past(wr_field) + (rev_q ? fw_t'('1) : fw_t'(1)))); // R1
  AST_FAIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> done && !wr_en); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en && vl_out <= vl_q); // R6
  AST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ff_q |-> vl_out == vl_q); // R7
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && vl_in == '0 |=> done && !wr_en && vl_out == '0); // R8
endmodule

// File: tb/cr_ffirst_seq_tb.sv
module cr_ffirst_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, rev = 0, ff_en = 0, fmt5 = 0, inv = 0, vli = 0, zz = 0, snz = 0;
  logic [3:0] vl_in = 0, op_tt = 0;
  logic [1:0] crbit = 0;
  logic [4:0] idx_a = 0, idx_b = 0, idx_t = 0;
  logic [15:0] pmask = 0;
  logic [31:0] cr_in = 0;
  logic wr_en, done;
  logic [2:0] wr_field;
  logic [3:0] wr_data, vl_out;

  cr_ffirst_seq dut_i (.clk, .rst_n, .start, .vl_in, .rev, .ff_en, .fmt5, .inv, .vli,
    .crbit, .zz, .snz, .op_tt, .idx_a, .idx_b, .idx_t, .pmask, .cr_in,
    .wr_en, .wr_field, .wr_data, .vl_out, .done);

  int n_chk = 0, n_bad = 0;
  int exp_n, exp_vl;
  int exp_f [16];
  logic [3:0] exp_d [16];

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model();
    logic [31:0] m;
    m = cr_in; exp_n = 0; exp_vl = vl_in;
    for (int k = 0; k < vl_in; k++) begin
      int e, fa, fb, ft;
      logic p, tb, av, bv;
      logic [3:0] fld;
      e = rev ? vl_in - 1 - k : k;
      p = pmask[e];
      if (!p && !zz) continue;
      if (fmt5) begin
        fa = (idx_a[4:2] + e) % 8; fb = (idx_b[4:2] + e) % 8; ft = (idx_t[4:2] + e) % 8;
        av = m[fa*4 + 3 - idx_a[1:0]];
        bv = m[fb*4 + 3 - idx_b[1:0]];
        fld = m[ft*4 +: 4];
        tb = p ? op_tt[{av, bv}] : snz;
        fld[3 - idx_t[1:0]] = tb;
      end else begin
        fa = (idx_a[2:0] + e) % 8; fb = (idx_b[2:0] + e) % 8; ft = (idx_t[2:0] + e) % 8;
        for (int j = 0; j < 4; j++)
          fld[j] = p ? op_tt[{m[fa*4+j], m[fb*4+j]}] : snz;
        tb = fld[3 - crbit];
      end
      m[ft*4 +: 4] = fld;
      exp_f[exp_n] = ft; exp_d[exp_n] = fld; exp_n++;
      if (ff_en && tb == inv) begin
        exp_vl = k + vli;
        break;
      end
    end
  endtask

  task automatic run(input string tag);
    int got;
    model();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    got = 0;
    for (int c = 0; c < 40; c++) begin
      if (wr_en) begin
        if (got < exp_n) begin
          check({tag, " R1 R9 field"}, wr_field, exp_f[got]);
          check({tag, " R2 R3 R4 R5 data"}, wr_data, exp_d[got]);
        end
        got++;
      end
      if (done) break;
      @(negedge clk);
    end
    check({tag, " R7 done"}, done, 1);
    check({tag, " R5 R7 write count"}, got, exp_n);
    check({tag, " R6 R7 vl_out"}, vl_out, exp_vl);
    @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] v, input logic rv, input logic ff, input logic f5,
                       input logic iv, input logic vi, input logic [1:0] cb, input logic z,
                       input logic s, input logic [3:0] tt, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] t, input logic [15:0] pm, input logic [31:0] cr);
    vl_in = v; rev = rv; ff_en = ff; fmt5 = f5; inv = iv; vli = vi; crbit = cb; zz = z;
    snz = s; op_tt = tt; idx_a = a; idx_b = b; idx_t = t; pmask = pm; cr_in = cr;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    check("R10 done", done, 0);
    check("R10 wr_en", wr_en, 0);
    check("R10 vl_out", vl_out, 0);
    rst_n = 1;
    @(negedge clk);
    // R8 zero length
    setup(0, 0, 1, 1, 0, 0, 0, 1, 0, 4'b1000, 0, 1, 2, 16'hffff, 32'h12345678);
    run("VL0 R8");
    // R4 field AND, forward, no fail-first
    setup(5, 0, 0, 0, 0, 0, 2, 0, 0, 4'b1000, 5'd0, 5'd3, 5'd6, 16'hffff, 32'hf0e1d2c3);
    run("AND3 R4");
    // R9 reverse cascade of bit AND
    setup(3, 1, 0, 1, 0, 0, 0, 0, 0, 4'b1000, 5'b10001, 5'b10101, 5'b10001, 16'hffff, 32'h4444_0000);
    run("cascade R9");
    // R6 fail-first excluding and including
    setup(6, 0, 1, 0, 0, 0, 1, 0, 0, 4'b1110, 5'd0, 5'd1, 5'd2, 16'hffff, 32'h00ffffff);
    run("ff excl R6");
    vli = 1;
    run("ff incl R6");
    inv = 1;
    run("ff inv R6");
    // R5 skip and one-fill
    setup(6, 0, 1, 1, 1, 1, 0, 0, 0, 4'b0001, 5'd4, 5'd9, 5'd14, 16'b101010, 32'hffffffff);
    run("skip R5");
    setup(4, 1, 1, 0, 0, 0, 3, 1, 1, 4'b0110, 5'd1, 5'd2, 5'd5, 16'b0101, 32'h89abcdef);
    run("onefill R5");
    for (int i = 0; i < 300; i++) begin
      setup(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
            5'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), $urandom);
      run("rand R1 R2 R3");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule